// File: doc/BRIEF.md
# Sleep/Wake Power-Mode Controller

This block keeps the one-bit power state of a battery-powered system. In full power it drives the main regulator on. In standby it drives the regulator off and the system runs only from a trickle supply. It lives in the always-on domain and runs from the low-rate standby clock. Three request lines reach it. The first is a wake-up receiver output, which is active high. The second is a real-time-clock alarm, which is active low. The third is a sleep request from the processor, which is active high.

Every request line is synchronised and then qualified digitally. A request counts only after the line has stayed asserted for a parameterised number of consecutive clock samples. The sleep line gets the longest hold time, because a false sleep request would cost the whole mission. Each entry into standby starts a blanking window. While the window runs, wake requests are thrown away, so shutdown transients on the supply cannot wake the system again at once. A second enable powers the data receiver. This enable is never on while the main regulator is off. It turns on one cycle after the regulator, so the main supply comes up first.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the state is full power: `standby_o`=0, `main_reg_en_o`=1, `rx_supply_en_o`=1. `main_reg_en_o` is always the inverse of `standby_o`.
- R2: In full power, `sleep_req_i`=1 moves the block to standby only if the line was high for at least SLEEP_HOLD consecutive clock samples. A pulse of SLEEP_HOLD-1 samples leaves the state unchanged.
- R3: `wake_rx_i`=1 counts as a wake request only after WAKE_RX_HOLD consecutive high samples. A shorter pulse is ignored.
- R4: `alarm_n_i` is active low: the value 0 means alarm. It counts as a wake request only after ALARM_HOLD consecutive low samples. A shorter low pulse is ignored.
- R5: Each entry into standby starts a window of BLANK_CYCLES clock cycles. During the window, wake requests do not change the state. A request that ends inside the window is discarded, not held over, so the block stays in standby after the window closes.
- R6: In standby, after the window has closed, a qualified wake request from either source returns the block to full power.
- R7: `rx_supply_en_o` is 0 whenever `main_reg_en_o` is 0. It falls on the same edge as `main_reg_en_o` and rises one cycle after it.
- R8: In full power, if a wake request and a sleep request are both qualified in the same cycle, the block stays in full power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-rate standby clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wake_rx_i | input | 1 | Wake-up receiver output, active high |
| alarm_n_i | input | 1 | Real-time-clock alarm, active low |
| sleep_req_i | input | 1 | Processor sleep request, active high |
| standby_o | output | 1 | Power state bit: 0 = full power, 1 = standby |
| main_reg_en_o | output | 1 | Main regulator enable |
| rx_supply_en_o | output | 1 | Data-receiver supply enable |

## Verification
Two functions can act in the same cycle. A qualified sleep request and a qualified wake request can meet while the block is in full power. The bench provokes this by raising `wake_rx_i` and `sleep_req_i` on the same clock and holding both well past the sleep hold time. The scoreboard must then still see full power. It then drops only the wake line while sleep stays high, and expects standby. This shows that the sleep request was qualified the whole time and lost to wake only by priority. The blanking window and a wake request also overlap on purpose: a wake pulse lies fully inside the window, and the state must not change either during the window or after it closes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic {
      PM_FULL    = 1'b0,
      PM_STANDBY = 1'b1
   } pm_state_e;

   // Bits needed to hold values 0..maxval
   function automatic int unsigned cnt_width(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/pmc_input_qual.sv
// Synchronises one request line and qualifies it by a run of asserted samples.
module pmc_input_qual #(
   parameter bit          ACTIVE_LOW  = 1'b0,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYCLES = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic qual_o
);
   localparam int unsigned CW = pmc_pkg::cnt_width(HOLD_CYCLES);
   localparam logic [CW-1:0] HOLD_C = CW'(HOLD_CYCLES);

   initial begin : p_elab_chk
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert (HOLD_CYCLES >= 1) else $error("HOLD_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES:0] chain;
   logic [CW-1:0]        run_cnt;
   logic                 sampled;

   // Normalise polarity so that 1 always means "asserted"
   generate
      if (ACTIVE_LOW) begin : g_inv
         assign chain[0] = ~raw_i;
      end else begin : g_dir
         assign chain[0] = raw_i;
      end
   endgenerate

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain[s+1] <= 1'b0;
         else         chain[s+1] <= chain[s];
      end
   end

   assign sampled = chain[SYNC_STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                run_cnt <= '0;
      else if (!sampled)          run_cnt <= '0;
      else if (run_cnt != HOLD_C) run_cnt <= run_cnt + 1'b1;
   end

   assign qual_o = (run_cnt == HOLD_C);

   AST_RUN_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_cnt <= HOLD_C); // R3
   AST_QUAL_FROM_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(qual_o) |-> $past(sampled)); // R2
   AST_DROP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sampled |=> !qual_o); // R4

endmodule

// File: rtl/pmc_blank_timer.sv
// Counts down the wake blanking window after each standby entry.
module pmc_blank_timer #(
   parameter int unsigned BLANK_CYCLES = 98304
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic active_o
);
   generate
      if (BLANK_CYCLES == 0) begin : g_none
         assign active_o = 1'b0;
      end else begin : g_count
         localparam int unsigned CW = pmc_pkg::cnt_width(BLANK_CYCLES);
         localparam logic [CW-1:0] LOAD_C = CW'(BLANK_CYCLES);
         logic [CW-1:0] left_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)             left_q <= '0;
            else if (start_i)        left_q <= LOAD_C;
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end

         assign active_o = (left_q != '0);

         AST_BLANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            start_i |=> (left_q == LOAD_C)); // R5
         AST_BLANK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (active_o && !start_i) |=> (left_q == $past(left_q) - 1'b1)); // R5
      end
   endgenerate

endmodule

// File: rtl/pmc_state_core.sv
// One-bit power state with arbitration and supply sequencing.
module pmc_state_core (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wake_any_i,
   input  logic sleep_q_i,
   input  logic blank_i,
   output logic enter_o,
   output logic standby_o,
   output logic main_en_o,
   output logic rx_en_o
);
   import pmc_pkg::*;

   pm_state_e state_q, state_d;
   logic      leave;
   logic      rx_q;

   // Wake has priority over sleep in full power
   assign enter_o = (state_q == PM_FULL) && sleep_q_i && !wake_any_i;
   assign leave   = (state_q == PM_STANDBY) && wake_any_i && !blank_i;

   always_comb begin
      state_d = state_q;
      if (enter_o)    state_d = PM_STANDBY;
      else if (leave) state_d = PM_FULL;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= PM_FULL;
      else         state_q <= state_d;
   end

   // Receiver supply: off with the main supply, on one cycle after it
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rx_q <= 1'b1;
      else         rx_q <= (state_d == PM_FULL) && (state_q == PM_FULL);
   end

   assign standby_o = (state_q == PM_STANDBY);
   assign main_en_o = (state_q == PM_FULL);
   assign rx_en_o   = rx_q;

   AST_WAKE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!standby_o && sleep_q_i && wake_any_i) |=> !standby_o); // R8
   AST_BLANK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (standby_o && blank_i) |=> standby_o); // R5
   AST_SLEEP_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(standby_o) |-> $past(sleep_q_i)); // R2
   AST_RX_NEEDS_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_en_o |-> main_en_o); // R7
   AST_RX_LAGS_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(main_en_o) |-> !rx_en_o); // R7
   AST_WAKE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(standby_o) |-> $past(wake_any_i)); // R6

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned WAKE_RX_HOLD = 8,
   parameter int unsigned ALARM_HOLD   = 2,
   parameter int unsigned SLEEP_HOLD   = 3277,
   parameter int unsigned BLANK_CYCLES = 98304
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wake_rx_i,
   input  logic alarm_n_i,
   input  logic sleep_req_i,
   output logic standby_o,
   output logic main_reg_en_o,
   output logic rx_supply_en_o
);
   initial begin : p_elab_chk
      assert (SLEEP_HOLD >= WAKE_RX_HOLD && SLEEP_HOLD >= ALARM_HOLD)
         else $error("sleep must be filtered at least as heavily as wake");
   end

   logic rx_wake_q, alarm_q, sleep_q, wake_any, blank, enter;

   pmc_input_qual #(.ACTIVE_LOW(1'b0), .SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(WAKE_RX_HOLD))
      i_qual_rx (.clk_i(clk_i), .rst_ni(rst_ni), .raw_i(wake_rx_i), .qual_o(rx_wake_q));

   pmc_input_qual #(.ACTIVE_LOW(1'b1), .SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(ALARM_HOLD))
      i_qual_alarm (.clk_i(clk_i), .rst_ni(rst_ni), .raw_i(alarm_n_i), .qual_o(alarm_q));

   pmc_input_qual #(.ACTIVE_LOW(1'b0), .SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(SLEEP_HOLD))
      i_qual_sleep (.clk_i(clk_i), .rst_ni(rst_ni), .raw_i(sleep_req_i), .qual_o(sleep_q));

   assign wake_any = rx_wake_q | alarm_q;

   pmc_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES))
      i_blank (.clk_i(clk_i), .rst_ni(rst_ni), .start_i(enter), .active_o(blank));

   pmc_state_core i_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wake_any_i(wake_any),
      .sleep_q_i (sleep_q),
      .blank_i   (blank),
      .enter_o   (enter),
      .standby_o (standby_o),
      .main_en_o (main_reg_en_o),
      .rx_en_o   (rx_supply_en_o)
   );

   AST_MAIN_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      main_reg_en_o != standby_o); // R1

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
   localparam int SYNC = 2;
   localparam int WK   = 4;
   localparam int AL   = 2;
   localparam int SLP  = 12;
   localparam int BLK  = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wake_rx = 1'b0, alarm_n = 1'b1, sleep_req = 1'b0;
   logic standby, main_en, rx_en;

   always #2 clk = ~clk; // 250 MHz

   pwr_mode_ctrl #(.SYNC_STAGES(SYNC), .WAKE_RX_HOLD(WK), .ALARM_HOLD(AL),
                   .SLEEP_HOLD(SLP), .BLANK_CYCLES(BLK)) i_pwr_mode_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .wake_rx_i(wake_rx), .alarm_n_i(alarm_n),
      .sleep_req_i(sleep_req), .standby_o(standby), .main_reg_en_o(main_en),
      .rx_supply_en_o(rx_en));

   typedef struct { bit sb; string tag; } exp_t;
   exp_t exp_q[$];
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   task automatic check(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic push_exp(input bit sb, input string tag);
      exp_t e;
      e.sb = sb; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: pops expectations and compares against the ports
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(standby, e.sb,  {e.tag, " standby"});
         check(main_en, ~e.sb, {e.tag, " main_en"});
         check(rx_en,   ~e.sb, {e.tag, " rx_en"});
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic drive_sleep(input int n);
      @(negedge clk) sleep_req = 1'b1; idle(n); sleep_req = 1'b0;
   endtask
   task automatic drive_wake(input int n);
      @(negedge clk) wake_rx = 1'b1; idle(n); wake_rx = 1'b0;
   endtask
   task automatic drive_alarm(input int n);
      @(negedge clk) alarm_n = 1'b0; idle(n); alarm_n = 1'b1;
   endtask

   initial begin : p_watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : p_drive
      idle(5);
      rst_n = 1'b1;
      idle(3);
      push_exp(1'b0, "R1 reset state");
      idle(2);

      drive_sleep(SLP - 1); idle(20);
      push_exp(1'b0, "R2 short sleep ignored");
      idle(2);
      drive_sleep(SLP); idle(6);
      push_exp(1'b1, "R2 sleep accepted");
      idle(2);

      // wake pulse entirely inside the blanking window
      drive_wake(10); idle(4);
      push_exp(1'b1, "R5 wake blanked");
      idle(50);
      push_exp(1'b1, "R5 wake not held over");
      idle(2);

      drive_wake(WK - 1); idle(10);
      push_exp(1'b1, "R3 short wake ignored");
      idle(2);
      drive_alarm(AL - 1); idle(10);
      push_exp(1'b1, "R4 short alarm ignored");
      idle(2);

      // qualified wake after window; check supply sequencing
      drive_wake(WK);
      for (int i = 0; i < 30 && !main_en; i++) @(negedge clk);
      check(main_en, 1'b1, "R6 wake returns to full power");
      check(rx_en, 1'b0, "R7 rx off in first full-power cycle");
      @(negedge clk);
      check(rx_en, 1'b1, "R7 rx on one cycle later");
      idle(3);
      push_exp(1'b0, "R6 full power after wake");
      idle(2);

      drive_sleep(SLP); idle(6);
      push_exp(1'b1, "R2 second sleep");
      idle(60);
      drive_alarm(AL); idle(8);
      push_exp(1'b0, "R4 alarm wake");
      idle(2);

      // wake and sleep qualified together
      @(negedge clk) begin wake_rx = 1'b1; sleep_req = 1'b1; end
      idle(3 * SLP);
      push_exp(1'b0, "R8 wake wins over sleep");
      idle(2);
      wake_rx = 1'b0;
      idle(10);
      push_exp(1'b1, "R8 sleep takes effect once wake drops");
      idle(2);
      sleep_req = 1'b0;
      idle(BLK + 10);
      drive_wake(WK); idle(8);
      push_exp(1'b0, "R6 final wake");

      wait (exp_q.size() == 0);
      idle(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule